// File: doc/BRIEF.md
# Four-Channel DMA Address and Count Register File

This block keeps the programming state of four DMA channels: a 16-bit base address and a 16-bit base count per channel, a working start address and a progress count, and two page bytes that extend each address. Software reaches every register through a byte-wide port. One shared byte pointer decides whether an address or count access touches the low or the high byte. Each channel access flips the pointer, and a separate strobe returns it to the low byte.

A transfer engine outside the block reports how far each channel has got by loading a progress value. Read-back of a channel's address or count shows the live position, derived from the base values and that progress. The block drives a 31-bit memory address and a transfer length for every channel. The parameter `WSHIFT` picks the unit size: 0 for byte-unit channels, and 1 for word-unit channels whose register offsets and address/count values are scaled by two.

Top module: `chanreg_file`

## Requirements
- R1: After reset every base, working address, progress, page and high-page register is 0, the byte pointer is 0 and `acc_rdata` is 0.
- R2: In channel space (`acc_space`=0), the offset shifted right by `WSHIFT` gives a 4-bit index: bits [2:1] pick the channel and bit 0 picks address (0) or count (1). Indexes 8..15 name no register: a write there changes nothing, a read returns 0, and neither moves the byte pointer.
- R3: Every read or write of a valid channel register flips the shared byte pointer (0 = low byte, 1 = high byte). A page access does not move it. `ptr_clear` forces it to 0 and wins over a flip in the same cycle.
- R4: A high-byte write sets bits [15:8] of the selected base register. It also reloads that channel's working address with the (new) base address shifted left by `WSHIFT`, and clears the channel's progress to 0.
- R5: A low-byte write sets only bits [7:0] of the selected base register. The working address and the progress stay as they were.
- R6: Reading the count register yields (base count << `WSHIFT`) minus progress, modulo 2^32.
- R7: Reading the address register yields working address plus progress, or minus progress when the channel's `dir_down` bit is 1.
- R8: The byte returned is bits [7:0] of the value shifted right by `WSHIFT` + 8 × pointer. It appears on `acc_rdata` on the clock edge that takes `acc_rd`, and holds until the next read. A write in the same cycle takes precedence, and the read is then dropped.
- R9: In page space (`acc_space`=1), offset bits [2:0] values 0..7 map to channels {none, 2, 3, 1, none, none, none, 0}. Writes to an unmapped offset are ignored, and reads of one return 0.
- R10: High-page space (`acc_space`=2) uses the same offset map as page space. Space 3 holds no register: writes are ignored and reads return 0.
- R11: `chan_addr` for channel n (bits n*31 +: 31) is the high page bits [6:0] at [30:24], ORed with the page at [23:16], ORed with the working address.
- R12: `chan_len` for channel n (bits n*(17+WSHIFT) +: 17+WSHIFT) is (base count + 1) << `WSHIFT`.
- R13: `prog_we` loads `prog_val` into the progress of channel `prog_ch`. A high-byte write to the same channel in the same cycle wins, and the progress becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_space | input | 2 | Register space: 0 channel, 1 page, 2 high page, 3 none |
| acc_ofs | input | 4+WSHIFT | Register offset within the space |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_wdata | input | 8 | Write data |
| ptr_clear | input | 1 | Force the byte pointer to the low byte |
| dir_down | input | 4 | Per-channel address decrement flag |
| prog_we | input | 1 | Progress load strobe |
| prog_ch | input | 2 | Channel whose progress is loaded |
| prog_val | input | 17+WSHIFT | Progress value |
| acc_rdata | output | 8 | Registered read data |
| chan_addr | output | 124 | Per-channel 31-bit memory address |
| chan_len | output | 4*(17+WSHIFT) | Per-channel transfer length |

## Verification
A byte-unit instance and a word-unit instance run side by side on identical stimulus. This separates errors in the `WSHIFT` scaling from errors in the decode. Each channel gets its own address and count pattern, so a swapped channel index or address/count select shows up at once. Progress is then loaded with both directions set across channels: count read-back tests the subtraction, and address read-back tells increment apart from decrement. Low-only writes, high writes against pending progress, writes to absent channels and a sweep of all eight page offsets in both page spaces separate the reload, pointer and mapping rules from one another.

// File: rtl/chanreg_pkg.sv
package chanreg_pkg;

    localparam int NCH  = 4;
    localparam int CH_W = $clog2(NCH);
    localparam int FAW  = 31;

    typedef enum logic [1:0] {
        SP_CHAN  = 2'd0,
        SP_PAGE  = 2'd1,
        SP_HPAGE = 2'd2,
        SP_NONE  = 2'd3
    } space_e;

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] idx;
    } page_slot_t;

    // offset -> channel for the page spaces; unlisted offsets hold nothing
    function automatic page_slot_t page_lookup(input logic [2:0] ofs);
        page_slot_t r;
        r = '0;
        case (ofs)
            3'd1:    begin r.hit = 1'b1; r.idx = CH_W'(2); end
            3'd2:    begin r.hit = 1'b1; r.idx = CH_W'(3); end
            3'd3:    begin r.hit = 1'b1; r.idx = CH_W'(1); end
            3'd7:    begin r.hit = 1'b1; r.idx = CH_W'(0); end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/chanreg_decode.sv
module chanreg_decode
    import chanreg_pkg::*;
#(
    parameter int WSHIFT = 0,
    localparam int OFS_W = 4 + WSHIFT
) (
    input  logic [1:0]       acc_space,
    input  logic [OFS_W-1:0] acc_ofs,
    output logic             chan_hit,
    output logic [CH_W-1:0]  chan_idx,
    output logic             is_cnt,
    output logic             pg_hit,
    output logic             hpg_hit,
    output logic [CH_W-1:0]  pg_idx
);

    logic [3:0] iport;
    page_slot_t slot;

    always_comb begin
        iport    = acc_ofs[OFS_W-1:WSHIFT];
        chan_hit = (space_e'(acc_space) == SP_CHAN) && !iport[3];
        chan_idx = iport[2:1];
        is_cnt   = iport[0];
        slot     = page_lookup(acc_ofs[2:0]);
        pg_hit   = (space_e'(acc_space) == SP_PAGE)  && slot.hit;
        hpg_hit  = (space_e'(acc_space) == SP_HPAGE) && slot.hit;
        pg_idx   = slot.idx;
    end

endmodule

// File: rtl/chanreg_readback.sv
module chanreg_readback #(
    parameter int WSHIFT = 0,
    localparam int AW = 16 + WSHIFT,
    localparam int PW = 17 + WSHIFT
) (
    input  logic          ptr,
    input  logic          is_cnt,
    input  logic          down,
    input  logic [AW-1:0] cur_addr,
    input  logic [15:0]   base_cnt,
    input  logic [PW-1:0] prog,
    output logic [7:0]    rd_byte
);

    logic [31:0] live_d;
    logic [31:0] scaled_d;

    always_comb begin
        if (is_cnt) begin
            live_d = (32'(base_cnt) << WSHIFT) - 32'(prog);
        end else if (down) begin
            live_d = 32'(cur_addr) - 32'(prog);
        end else begin
            live_d = 32'(cur_addr) + 32'(prog);
        end
        scaled_d = live_d >> WSHIFT;
        rd_byte  = ptr ? scaled_d[15:8] : scaled_d[7:0];
    end

endmodule

// File: rtl/chanreg_addr_gen.sv
module chanreg_addr_gen
    import chanreg_pkg::*;
#(
    parameter int WSHIFT = 0,
    localparam int AW = 16 + WSHIFT,
    localparam int LW = 17 + WSHIFT
) (
    input  logic [NCH-1:0][AW-1:0]  cur_addr,
    input  logic [NCH-1:0][7:0]     page,
    input  logic [NCH-1:0][7:0]     hpage,
    input  logic [NCH-1:0][15:0]    base_cnt,
    output logic [NCH-1:0][FAW-1:0] full_addr,
    output logic [NCH-1:0][LW-1:0]  xfer_len
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        always_comb begin
            full_addr[ch] = {hpage[ch][6:0], 24'b0}
                          | {7'b0, page[ch], 16'b0}
                          | FAW'(cur_addr[ch]);
            xfer_len[ch]  = (LW'(base_cnt[ch]) + LW'(1)) << WSHIFT;
        end
    end

endmodule

// File: rtl/chanreg_file.sv
module chanreg_file
    import chanreg_pkg::*;
#(
    parameter int WSHIFT = 0,
    localparam int OFS_W = 4 + WSHIFT,
    localparam int AW    = 16 + WSHIFT,
    localparam int PW    = 17 + WSHIFT,
    localparam int LW    = 17 + WSHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         acc_space,
    input  logic [OFS_W-1:0]   acc_ofs,
    input  logic               acc_wr,
    input  logic               acc_rd,
    input  logic [7:0]         acc_wdata,
    input  logic               ptr_clear,
    input  logic [NCH-1:0]     dir_down,
    input  logic               prog_we,
    input  logic [CH_W-1:0]    prog_ch,
    input  logic [PW-1:0]      prog_val,
    output logic [7:0]         acc_rdata,
    output logic [NCH*FAW-1:0] chan_addr,
    output logic [NCH*LW-1:0]  chan_len
);

    typedef struct packed {
        logic                   ptr;
        logic [NCH-1:0][15:0]   base_a;
        logic [NCH-1:0][15:0]   base_c;
        logic [NCH-1:0][AW-1:0] cur_a;
        logic [NCH-1:0][PW-1:0] prog;
        logic [NCH-1:0][7:0]    page;
        logic [NCH-1:0][7:0]    hpage;
        logic [7:0]             rdata;
    } state_t;

    state_t st_d, st_q;

    logic            chan_hit, is_cnt, pg_hit, hpg_hit;
    logic [CH_W-1:0] chan_idx, pg_idx;
    logic [7:0]      rb_byte;
    logic [15:0]     new_base_a;
    logic            ptr_now;

    logic [NCH-1:0][FAW-1:0] full_arr;
    logic [NCH-1:0][LW-1:0]  len_arr;

    chanreg_decode #(.WSHIFT(WSHIFT)) dec_i (
        .acc_space (acc_space),
        .acc_ofs   (acc_ofs),
        .chan_hit  (chan_hit),
        .chan_idx  (chan_idx),
        .is_cnt    (is_cnt),
        .pg_hit    (pg_hit),
        .hpg_hit   (hpg_hit),
        .pg_idx    (pg_idx)
    );

    chanreg_readback #(.WSHIFT(WSHIFT)) rb_i (
        .ptr      (st_q.ptr),
        .is_cnt   (is_cnt),
        .down     (dir_down[chan_idx]),
        .cur_addr (st_q.cur_a[chan_idx]),
        .base_cnt (st_q.base_c[chan_idx]),
        .prog     (st_q.prog[chan_idx]),
        .rd_byte  (rb_byte)
    );

    chanreg_addr_gen #(.WSHIFT(WSHIFT)) ag_i (
        .cur_addr  (st_q.cur_a),
        .page      (st_q.page),
        .hpage     (st_q.hpage),
        .base_cnt  (st_q.base_c),
        .full_addr (full_arr),
        .xfer_len  (len_arr)
    );

    always_comb begin
        st_d       = st_q;
        new_base_a = st_q.base_a[chan_idx];

        if (prog_we) begin
            st_d.prog[prog_ch] = prog_val;
        end

        if (acc_wr) begin
            if (chan_hit) begin
                if (st_q.ptr) begin
                    if (is_cnt) begin
                        st_d.base_c[chan_idx][15:8] = acc_wdata;
                    end else begin
                        new_base_a[15:8]            = acc_wdata;
                        st_d.base_a[chan_idx][15:8] = acc_wdata;
                    end
                    st_d.cur_a[chan_idx] = AW'(new_base_a) << WSHIFT;
                    st_d.prog[chan_idx]  = '0;
                end else if (is_cnt) begin
                    st_d.base_c[chan_idx][7:0] = acc_wdata;
                end else begin
                    st_d.base_a[chan_idx][7:0] = acc_wdata;
                end
                st_d.ptr = ~st_q.ptr;
            end else if (pg_hit) begin
                st_d.page[pg_idx] = acc_wdata;
            end else if (hpg_hit) begin
                st_d.hpage[pg_idx] = acc_wdata;
            end
        end else if (acc_rd) begin
            if (chan_hit) begin
                st_d.rdata = rb_byte;
                st_d.ptr   = ~st_q.ptr;
            end else if (pg_hit) begin
                st_d.rdata = st_q.page[pg_idx];
            end else if (hpg_hit) begin
                st_d.rdata = st_q.hpage[pg_idx];
            end else begin
                st_d.rdata = '0;
            end
        end

        if (ptr_clear) begin
            st_d.ptr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_now   = st_q.ptr;
    assign acc_rdata = st_q.rdata;
    assign chan_addr = full_arr;
    assign chan_len  = len_arr;

endmodule

// File: rtl/chanreg_file_chk.sv
module chanreg_file_chk
    import chanreg_pkg::*;
#(
    parameter int WSHIFT = 0,
    localparam int OFS_W = 4 + WSHIFT
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         acc_space,
    input logic [OFS_W-1:0]   acc_ofs,
    input logic               acc_wr,
    input logic               acc_rd,
    input logic               ptr_clear,
    input logic [7:0]         acc_rdata,
    input logic [NCH*FAW-1:0] chan_addr,
    input logic               ptr_now
);

    logic chan_acc;
    logic unmapped_pg;

    assign chan_acc    = (acc_wr || acc_rd) && (acc_space == 2'd0) && !acc_ofs[OFS_W-1];
    assign unmapped_pg = acc_wr && (acc_space == 2'd1) && !page_lookup(acc_ofs[2:0]).hit;

    // R3: the clear strobe leaves the pointer on the low byte
    assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clear |=> !ptr_now);

    // R3: a channel access without clear flips the pointer
    assert_ptr_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_acc && !ptr_clear) |=> (ptr_now != $past(ptr_now)));

    // R5: a low-byte write leaves every memory address unchanged
    assert_low_write_no_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_acc && acc_wr && !ptr_now) |=> $stable(chan_addr));

    // R8: read data only moves on a read strobe
    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> $stable(acc_rdata));

    // R9: a write to an unmapped page offset changes no address
    assert_unmapped_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_pg |=> $stable(chan_addr));

endmodule

bind chanreg_file chanreg_file_chk #(.WSHIFT(WSHIFT)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_space (acc_space),
    .acc_ofs   (acc_ofs),
    .acc_wr    (acc_wr),
    .acc_rd    (acc_rd),
    .ptr_clear (ptr_clear),
    .acc_rdata (acc_rdata),
    .chan_addr (chan_addr),
    .ptr_now   (ptr_now)
);

// File: tb/chanreg_file_tb.sv
module chanreg_file_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  acc_space = '0;
    logic [3:0]  ofs_n = '0;
    logic [4:0]  ofs_w = '0;
    logic        acc_wr = 1'b0, acc_rd = 1'b0, ptr_clear = 1'b0;
    logic [7:0]  acc_wdata = '0;
    logic [3:0]  dir_down = 4'b0101;
    logic        prog_we = 1'b0;
    logic [1:0]  prog_ch = '0;
    logic [17:0] prog_val = '0;

    logic [7:0]   rdata_n, rdata_w;
    logic [123:0] addr_n, addr_w;
    logic [67:0]  len_n;
    logic [71:0]  len_w;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_ba [4];
    logic [15:0] m_bc [4];
    logic [15:0] m_cb [4];
    logic [31:0] m_pr [4];
    logic [7:0]  m_pg [4];
    logic [7:0]  m_hp [4];
    logic        m_ptr;

    always #5 clk = ~clk;

    chanreg_file #(.WSHIFT(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_space(acc_space), .acc_ofs(ofs_n),
        .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_wdata(acc_wdata), .ptr_clear(ptr_clear),
        .dir_down(dir_down), .prog_we(prog_we), .prog_ch(prog_ch), .prog_val(prog_val[16:0]),
        .acc_rdata(rdata_n), .chan_addr(addr_n), .chan_len(len_n)
    );

    chanreg_file #(.WSHIFT(1)) dut_w (
        .clk(clk), .rst_n(rst_n), .acc_space(acc_space), .acc_ofs(ofs_w),
        .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_wdata(acc_wdata), .ptr_clear(ptr_clear),
        .dir_down(dir_down), .prog_we(prog_we), .prog_ch(prog_ch), .prog_val(prog_val),
        .acc_rdata(rdata_w), .chan_addr(addr_w), .chan_len(len_w)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input int s, input int ch, input logic sel, input logic p);
        logic [31:0] v;
        if (sel) v = (32'(m_bc[ch]) << s) - m_pr[ch];
        else begin
            v = 32'(m_cb[ch]) << s;
            v = dir_down[ch] ? v - m_pr[ch] : v + m_pr[ch];
        end
        v = v >> s;
        return p ? v[15:8] : v[7:0];
    endfunction

    function automatic logic [30:0] exp_addr(input int s, input int ch);
        return {m_hp[ch][6:0], 24'b0} | {7'b0, m_pg[ch], 16'b0} | (31'(m_cb[ch]) << s);
    endfunction

    function automatic logic [31:0] exp_len(input int s, input int ch);
        return (32'(m_bc[ch]) + 32'd1) << s;
    endfunction

    // one cycle of stimulus, driven at the falling edge; returns at the next falling edge
    task automatic access(input logic [1:0] sp, input logic [3:0] ofs, input logic wr,
                          input logic rd, input logic clr, input logic [7:0] d,
                          input logic pwe, input int pch, input logic [31:0] pval);
        @(negedge clk);
        acc_space = sp;
        ofs_n     = ofs;
        ofs_w     = (sp == 2'd0) ? {ofs, 1'b1} : {1'b0, ofs};
        acc_wr    = wr; acc_rd = rd; ptr_clear = clr; acc_wdata = d;
        prog_we   = pwe; prog_ch = 2'(pch); prog_val = pval[17:0];
        @(negedge clk);
        acc_wr = 1'b0; acc_rd = 1'b0; ptr_clear = 1'b0; prog_we = 1'b0;
    endtask

    task automatic model_chan_wr(input int ch, input logic sel, input logic [7:0] d);
        if (m_ptr) begin
            if (sel) m_bc[ch][15:8] = d; else m_ba[ch][15:8] = d;
            m_cb[ch] = m_ba[ch];
            m_pr[ch] = 0;
        end else begin
            if (sel) m_bc[ch][7:0] = d; else m_ba[ch][7:0] = d;
        end
        m_ptr = ~m_ptr;
    endtask

    task automatic chan_wr(input int ch, input logic sel, input logic [7:0] d);
        model_chan_wr(ch, sel, d);
        access(2'd0, {1'b0, 2'(ch), sel}, 1'b1, 1'b0, 1'b0, d, 1'b0, 0, 0);
    endtask

    task automatic chan_rd(input string tag, input int ch, input logic sel);
        logic [7:0] en, ew;
        en = exp_rd(0, ch, sel, m_ptr);
        ew = exp_rd(1, ch, sel, m_ptr);
        access(2'd0, {1'b0, 2'(ch), sel}, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 0, 0);
        m_ptr = ~m_ptr;
        check({tag, " byte"}, 32'(rdata_n), 32'(en));
        check({tag, " word-unit byte"}, 32'(rdata_w), 32'(ew));
    endtask

    task automatic set_prog(input int ch, input logic [31:0] v);
        m_pr[ch] = v;
        access(2'd3, 4'd0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, ch, v);
    endtask

    task automatic clear_ptr();
        m_ptr = 1'b0;
        access(2'd3, 4'd0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 0, 0);
    endtask

    task automatic check_outputs(input string tag);
        for (int ch = 0; ch < 4; ch++) begin
            check({tag, " addr"}, 32'(addr_n[ch*31 +: 31]), 32'(exp_addr(0, ch)));
            check({tag, " word-unit addr"}, 32'(addr_w[ch*31 +: 31]), 32'(exp_addr(1, ch)));
            check("R12 len", 32'(len_n[ch*17 +: 17]), exp_len(0, ch));
            check("R12 word-unit len", 32'(len_w[ch*18 +: 18]), exp_len(1, ch));
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int ch = 0; ch < 4; ch++) begin
            m_ba[ch] = 0; m_bc[ch] = 0; m_cb[ch] = 0; m_pr[ch] = 0; m_pg[ch] = 0; m_hp[ch] = 0;
        end
        m_ptr = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rdata", 32'(rdata_n), 0);
        check("R1 word-unit rdata", 32'(rdata_w), 0);
        check_outputs("R1 R11");
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5: full programming of each channel with distinct patterns
        for (int ch = 0; ch < 4; ch++) begin
            logic [15:0] a, c;
            a = 16'hA55A ^ (16'(ch) * 16'h0F0F);
            c = 16'h0100 * 16'(ch) + 16'h003C + 16'(ch);
            chan_wr(ch, 1'b0, a[7:0]);
            chan_wr(ch, 1'b0, a[15:8]);
            chan_wr(ch, 1'b1, c[7:0]);
            chan_wr(ch, 1'b1, c[15:8]);
        end
        check_outputs("R4 R11");
        for (int ch = 0; ch < 4; ch++) begin
            chan_rd("R2 R7 R8 addr", ch, 1'b0);
            chan_rd("R2 R7 R8 addr", ch, 1'b0);
            chan_rd("R2 R6 R8 count", ch, 1'b1);
            chan_rd("R2 R6 R8 count", ch, 1'b1);
        end

        // R13 R6 R7: progress with mixed directions, including a wrap below zero
        set_prog(0, 32'h0123);
        set_prog(1, 32'h0007);
        set_prog(2, 32'hF000);
        set_prog(3, 32'h0400);
        for (int ch = 0; ch < 4; ch++) begin
            chan_rd("R13 R7 progressed addr", ch, 1'b0);
            chan_rd("R13 R7 progressed addr", ch, 1'b0);
            chan_rd("R13 R6 progressed count", ch, 1'b1);
            chan_rd("R13 R6 progressed count", ch, 1'b1);
        end

        // R5: low-only write keeps working address and progress
        chan_wr(1, 1'b0, 8'h99);
        clear_ptr();
        check_outputs("R5");
        chan_rd("R5 addr after low write", 1, 1'b0);
        chan_rd("R5 addr after low write", 1, 1'b0);

        // R4: high write reloads working address and drops progress
        chan_wr(2, 1'b1, 8'h11);
        chan_wr(2, 1'b1, 8'h22);
        check_outputs("R4");
        chan_rd("R4 count after reload", 2, 1'b1);
        chan_rd("R4 count after reload", 2, 1'b1);
        chan_rd("R4 addr after reload", 2, 1'b0);
        chan_rd("R4 addr after reload", 2, 1'b0);

        // R3: page access leaves the pointer alone, clear returns to low byte
        chan_rd("R3 low byte", 0, 1'b0);
        access(2'd1, 4'd5, 1'b1, 1'b0, 1'b0, 8'hEE, 1'b0, 0, 0);
        chan_rd("R3 high byte after page access", 0, 1'b0);
        chan_rd("R3 low byte", 0, 1'b0);
        clear_ptr();
        chan_rd("R3 low byte after clear", 0, 1'b0);
        m_ptr = 1'b0;
        access(2'd0, 4'd2, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 0, 0);
        chan_rd("R3 clear wins over flip", 1, 1'b0);
        clear_ptr();

        // R2: indexes 8..15 hold nothing and do not move the pointer
        access(2'd0, 4'd9, 1'b1, 1'b0, 1'b0, 8'h77, 1'b0, 0, 0);
        access(2'd0, 4'd14, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 0, 0);
        check("R2 absent channel read", 32'(rdata_n), 0);
        check("R2 word-unit absent channel read", 32'(rdata_w), 0);
        check_outputs("R2");
        chan_rd("R2 pointer unmoved", 3, 1'b1);
        clear_ptr();

        // R9 R10 R11: sweep all page offsets in both page spaces and the empty space
        for (int o = 0; o < 8; o++) begin
            int mc;
            mc = (o == 1) ? 2 : (o == 2) ? 3 : (o == 3) ? 1 : (o == 7) ? 0 : -1;
            access(2'd1, 4'(o), 1'b1, 1'b0, 1'b0, 8'h40 + 8'(o), 1'b0, 0, 0);
            access(2'd2, 4'(o), 1'b1, 1'b0, 1'b0, 8'hC8 + 8'(o), 1'b0, 0, 0);
            access(2'd3, 4'(o), 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 0, 0);
            if (mc >= 0) begin
                m_pg[mc] = 8'h40 + 8'(o);
                m_hp[mc] = 8'hC8 + 8'(o);
            end
        end
        check_outputs("R9 R10 R11");
        for (int o = 0; o < 8; o++) begin
            int mc;
            mc = (o == 1) ? 2 : (o == 2) ? 3 : (o == 3) ? 1 : (o == 7) ? 0 : -1;
            access(2'd1, 4'(o), 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 0, 0);
            check("R9 page read", 32'(rdata_n), (mc >= 0) ? 32'(m_pg[mc]) : 0);
            access(2'd2, 4'(o), 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 0, 0);
            check("R10 high page read", 32'(rdata_w), (mc >= 0) ? 32'(m_hp[mc]) : 0);
        end
        access(2'd3, 4'd1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 0, 0);
        check("R10 empty space read", 32'(rdata_n), 0);

        // R13: high write beats a progress load to the same channel
        set_prog(3, 32'h0055);
        chan_wr(3, 1'b1, 8'h10);
        model_chan_wr(3, 1'b1, 8'h02);
        access(2'd0, 4'd7, 1'b1, 1'b0, 1'b0, 8'h02, 1'b1, 3, 32'h0033);
        chan_rd("R13 priority count", 3, 1'b1);
        chan_rd("R13 priority count", 3, 1'b1);
        check_outputs("R13");

        // R8: a write with a read in the same cycle leaves read data alone
        begin
            logic [7:0] keep_n;
            keep_n = rdata_n;
            model_chan_wr(0, 1'b0, 8'h5A);
            access(2'd0, 4'd0, 1'b1, 1'b1, 1'b0, 8'h5A, 1'b0, 0, 0);
            check("R8 read dropped under write", 32'(rdata_n), 32'(keep_n));
        end

        finish_run();
    end

endmodule